// File: doc/BRIEF.md
# Card Host Event Status and Interrupt Register

This block holds the event status word and the interrupt enable word of a memory-card host controller. Both sit behind a plain 32-bit register bus. Single-cycle pulses arrive from the command, data and card-detect logic. Each pulse sets a sticky flag. Software reads the status word and acknowledges it by writing the same value back: every bit written as 1 is cleared.

Three level flags are shown live next to the sticky flags and are never latched: read buffer ready, write buffer ready, and bus clock running. A two-bit write CRC status code from the card is captured in the status word and decoded into a timeout flag and a CRC failure flag. A summary output is high while any error flag is set. The interrupt enable word chooses which sources drive the single registered interrupt line.

Top module: `card_evt_status`

## Requirements
- R1: After reset, every sticky flag, the write CRC code, every enable bit and `irq_o` are 0.
- R2: A pulse on `evt_i` sets a sticky status bit, and the bit holds until it is cleared. The mapping from `evt_i` bit to status bit is: 0→0 (read timeout), 1→1 (response timeout), 2→2 (write CRC error), 3→3 (read CRC error), 4→5 (response CRC error), 5→11 (read/data done), 6→12 (write done), 7→13 (command response end), 8→30 (card removal), 9→31 (card insertion).
- R3: A bus write to the status address (`STAT_ADDR`) clears each status bit written as 1. Bits written as 0 keep their value.
- R4: If a pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: Status bits 8 (`lv_clk_run`), 7 (`lv_rd_rdy`) and 6 (`lv_wr_rdy`) follow their inputs in the same cycle and are not latched.
- R6: When `evt_i[2]` pulses, `wcrc_code_i` is captured into status bits 10:9. Writing 1 to bit 9 or bit 10 clears the code to 0, unless `evt_i[2]` pulses in the same cycle.
- R7: `wcrc_timeout` is high when the captured code is 2. `wcrc_fail` is high when the code is 1 or 3.
- R8: `err_any` is high exactly when one of status bits 5, 3, 2, 1 or 0 is set. Other set bits do not raise it.
- R9: The enable register is at `IEN_ADDR` and reads back only bits 15, 14 and 4..0, so a write of all ones reads 0x0000C01F. Each enable bit gates one status bit: 0→11, 1→12, 2→13, 3→6, 4→7, 14→30, 15→31.
- R10: `irq_o` rises one clock edge after an enabled source is set. While the enable register is 0, every source is masked and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Word address for reads and writes |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| evt_i | input | 10 | Event pulses (mapping in R2) |
| wcrc_code_i | input | 2 | Write CRC status code, captured on `evt_i[2]` |
| lv_rd_rdy | input | 1 | Read buffer ready level |
| lv_wr_rdy | input | 1 | Write buffer ready level |
| lv_clk_run | input | 1 | Card bus clock running level |
| err_any | output | 1 | Error summary |
| wcrc_timeout | output | 1 | Captured code means no CRC status was returned |
| wcrc_fail | output | 1 | Captured code means a CRC failure |
| irq_o | output | 1 | Registered interrupt |

## Verification
The main table walks pulse and clear patterns through the status word in turn:
- single events;
- several events in one cycle;
- partial clears that must leave neighbours untouched;
- a clear that collides with a new pulse on the same bit;
- a full clear.

These patterns tell a wrong bit mapping apart from a wrong clear mask or a wrong collision priority. Directed cases cover the live bits and show they are not latched. They check each write CRC code value against the two decode outputs, and error versus non-error bits against the summary. For the interrupt they cover masked and unmasked sources, including a live source, and the one-cycle latency of `irq_o`.

// File: rtl/card_evt_status.sv
module card_evt_status #(
  parameter int AW = 4,
  parameter logic [AW-1:0] STAT_ADDR = 4'h1,
  parameter logic [AW-1:0] IEN_ADDR  = 4'h9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [9:0]    evt_i,
  input  logic [1:0]    wcrc_code_i,
  input  logic          lv_rd_rdy,
  input  logic          lv_wr_rdy,
  input  logic          lv_clk_run,
  output logic          err_any,
  output logic          wcrc_timeout,
  output logic          wcrc_fail,
  output logic          irq_o
);
  localparam logic [31:0] STICKY_MASK = 32'hC000_382F;
  localparam logic [31:0] ERR_MASK    = 32'h0000_002F;
  localparam logic [15:0] IEN_MASK    = 16'hC01F;

  logic [31:0] sticky_q;
  logic [1:0]  code_q;
  logic [15:0] ien_q;
  logic        irq_q;

  logic [31:0] set_vec, clr_vec, view;
  logic [15:0] src;
  logic        stat_wr, ien_wr;

  assign stat_wr = bus_wr && (bus_addr == STAT_ADDR);
  assign ien_wr  = bus_wr && (bus_addr == IEN_ADDR);
  assign clr_vec = stat_wr ? bus_wdata : 32'h0;

  assign set_vec = {evt_i[9], evt_i[8], 16'h0, evt_i[7], evt_i[6], evt_i[5],
                    5'h0, evt_i[4], 1'b0, evt_i[3:0]};

  assign view = sticky_q | {21'h0, code_q, lv_clk_run, lv_rd_rdy, lv_wr_rdy, 6'h0};

  assign src = {view[31], view[30], 9'h0, view[7], view[6],
                view[13], view[12], view[11]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sticky_q <= '0;
      code_q   <= '0;
      ien_q    <= '0;
      irq_q    <= 1'b0;
    end else begin
      sticky_q <= ((sticky_q & ~clr_vec) | set_vec) & STICKY_MASK;
      if (evt_i[2])
        code_q <= wcrc_code_i;
      else if (clr_vec[10] || clr_vec[9])
        code_q <= '0;
      if (ien_wr)
        ien_q <= bus_wdata[15:0] & IEN_MASK;
      irq_q <= |(src & ien_q);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == STAT_ADDR)
      bus_rdata = view;
    else if (bus_addr == IEN_ADDR)
      bus_rdata = {16'h0, ien_q};
  end

  assign err_any      = |(sticky_q & ERR_MASK);
  assign wcrc_timeout = (code_q == 2'd2);
  assign wcrc_fail    = (code_q == 2'd1) || (code_q == 2'd3);
  assign irq_o        = irq_q;
endmodule

module card_evt_status_chk #(
  parameter int AW = 4,
  parameter logic [AW-1:0] STAT_ADDR = 4'h1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic [31:0]   bus_wdata,
  input logic [9:0]    evt_i,
  input logic          err_any,
  input logic          irq_o,
  input logic [31:0]   sticky_q,
  input logic [15:0]   ien_q
);
  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_q[31] && !(bus_wr && bus_addr == STAT_ADDR && bus_wdata[31])) |=> sticky_q[31]);

  // R3
  clear_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == STAT_ADDR && bus_wdata[13] && !evt_i[7]) |=> !sticky_q[13]);

  // R4
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i[7] |=> sticky_q[13]);

  // R8
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_any) |-> $past(|evt_i[4:0]));

  // R10
  all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == 16'h0) |=> !irq_o);
endmodule

bind card_evt_status card_evt_status_chk #(.AW(AW), .STAT_ADDR(STAT_ADDR)) u_chk (.*);

// File: tb/card_evt_status_tb.sv
module card_evt_status_tb;
  localparam logic [3:0] STAT = 4'h1;
  localparam logic [3:0] IEN  = 4'h9;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  bus_addr = STAT;
  logic        bus_wr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [9:0]  evt_i = 0;
  logic [1:0]  wcrc_code_i = 0;
  logic        lv_rd_rdy = 0, lv_wr_rdy = 0, lv_clk_run = 0;
  logic        err_any, wcrc_timeout, wcrc_fail, irq_o;
  int          checks = 0, fails = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  card_evt_status #(.AW(4), .STAT_ADDR(STAT), .IEN_ADDR(IEN)) u_dut (.*);

  // {evt, code, clear, expected status}
  localparam logic [75:0] VEC [12] = '{
    {10'h080, 2'd0, 32'h0000_0000, 32'h0000_2000},
    {10'h021, 2'd0, 32'h0000_0000, 32'h0000_2801},
    {10'h000, 2'd0, 32'h0000_2000, 32'h0000_0801},
    {10'h200, 2'd0, 32'h0000_0801, 32'h8000_0000},
    {10'h110, 2'd0, 32'h0000_0000, 32'hC000_0020},
    {10'h200, 2'd0, 32'h8000_0000, 32'hC000_0020},
    {10'h000, 2'd0, 32'hFFFF_FFFF, 32'h0000_0000},
    {10'h04A, 2'd0, 32'h0000_0000, 32'h0000_100A},
    {10'h004, 2'd2, 32'h0000_100A, 32'h0000_0404},
    {10'h000, 2'd0, 32'h0000_0600, 32'h0000_0004},
    {10'h000, 2'd0, 32'h0000_0004, 32'h0000_0000},
    {10'h004, 2'd1, 32'h0000_0200, 32'h0000_0204}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    tick();
    bus_wr = 0; bus_addr = STAT;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
    bus_addr = STAT;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) tick();
    rd(STAT, r); chk("R1 status", r, 0);
    rd(IEN, r);  chk("R1 enable", r, 0);
    chk("R1 irq", {31'h0, irq_o}, 0);
    rst_n = 1;
    tick();

    for (int i = 0; i < 12; i++) begin
      evt_i = VEC[i][75:66];
      wcrc_code_i = VEC[i][65:64];
      if (VEC[i][63:32] != 0) begin
        bus_addr = STAT; bus_wdata = VEC[i][63:32]; bus_wr = 1;
      end
      tick();
      evt_i = 0; bus_wr = 0;
      rd(STAT, r);
      chk($sformatf("R2 R3 R4 R6 vector %0d", i), r, VEC[i][31:0]);
      if (i == 8) begin
        chk("R7 timeout code 2", {31'h0, wcrc_timeout}, 1);
        chk("R7 fail code 2", {31'h0, wcrc_fail}, 0);
      end
    end
    chk("R7 fail code 1", {31'h0, wcrc_fail}, 1);
    chk("R7 timeout code 1", {31'h0, wcrc_timeout}, 0);
    chk("R8 err with bit 2", {31'h0, err_any}, 1);
    wcrc_code_i = 3; evt_i = 10'h004; tick(); evt_i = 0;
    chk("R7 fail code 3", {31'h0, wcrc_fail}, 1);
    wr(STAT, 32'hFFFF_FFFF);
    rd(STAT, r); chk("R6 code cleared", r, 0);
    chk("R7 no flags after clear", {30'h0, wcrc_timeout, wcrc_fail}, 0);

    evt_i = 10'h3E0; tick(); evt_i = 0;
    chk("R8 non-error bits leave summary low", {31'h0, err_any}, 0);
    evt_i = 10'h010; tick(); evt_i = 0;
    chk("R8 response CRC error raises summary", {31'h0, err_any}, 1);
    wr(STAT, 32'hFFFF_FFFF);

    lv_rd_rdy = 1; lv_wr_rdy = 1; lv_clk_run = 1;
    rd(STAT, r); chk("R5 live bits shown", r, 32'h0000_01C0);
    lv_rd_rdy = 0; lv_wr_rdy = 0; lv_clk_run = 0;
    tick();
    rd(STAT, r); chk("R5 live bits not latched", r, 0);

    wr(IEN, 32'hFFFF_FFFF);
    rd(IEN, r); chk("R9 enable readback", r, 32'h0000_C01F);
    wr(IEN, 32'h0000_0004);
    evt_i = 10'h040; tick(); evt_i = 0;
    tick();
    chk("R10 masked source gives no irq", {31'h0, irq_o}, 0);
    evt_i = 10'h080; tick(); evt_i = 0;
    chk("R10 irq not yet", {31'h0, irq_o}, 0);
    tick();
    chk("R10 irq after one edge", {31'h0, irq_o}, 1);
    wr(IEN, 0);
    tick();
    chk("R10 enable zero masks irq", {31'h0, irq_o}, 0);
    wr(STAT, 32'hFFFF_FFFF);
    wr(IEN, 32'h0000_0008);
    lv_wr_rdy = 1; tick(); tick();
    chk("R9 live write-ready source", {31'h0, irq_o}, 1);
    lv_wr_rdy = 0; tick(); tick();
    chk("R9 live source released", {31'h0, irq_o}, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule